// File: doc/BRIEF.md
# I2C Remote Address Alias Remapper

This block sits beside the target-side engine of a local I2C bus and decides, for each received 7-bit address, whether the transaction is meant for a remote deserializer or for a peripheral that sits behind it on a serial link. A matching transaction is forwarded with a one-cycle strobe, the address to put on the link, and the unchanged read/write bit. An address that matches nothing produces no strobe, so the local engine can NACK it.

Three programmable registers drive the decision. The first holds the remote deserializer ID and a freeze bit. The second holds the physical address of the remote peripheral. The third holds the alias the local bus uses for that peripheral. An address equal to the alias leaves with the physical ID in its place. An address equal to the deserializer ID leaves unchanged. A zero in either ID turns its match off.

When the link reports receive lock, the deserializer ID is loaded from the link side. Software can set the freeze bit to block this load and keep the value it wrote.

Top module: `i2c_alias_remap`

## Requirements
- R1: After reset all three registers read 0x00, `fwd_valid` is low, and no received address produces a forward.
- R2: Register layouts are as follows. Select 0 is the deserializer register: ID in bits 7:1, freeze in bit 0. Select 1 is the peripheral physical ID and select 2 is the alias, each with its ID in bits 7:1 and bit 0 reading 0 whatever is written. Select 3 reads 0x00.
- R3: An address equal to the nonzero deserializer ID is forwarded with its address unchanged and `fwd_to_dev` high.
- R4: An address equal to the nonzero alias is forwarded with `fwd_addr` set to the physical peripheral ID and `fwd_to_dev` low.
- R5: An alias of zero never matches.
- R6: A deserializer ID of zero never matches.
- R7: When an address equals both IDs, the deserializer match is taken.
- R8: An address that matches neither ID gives no `fwd_valid`.
- R9: The deserializer ID is loaded from `link_dev_id` only in the cycle after `link_lock` rises. While lock stays high, changes on `link_dev_id` are ignored.
- R10: While the freeze bit is set, a lock rise leaves the deserializer ID as written.
- R11: When a software write to the deserializer register and a lock-rise load fall in the same cycle, the written value is kept.
- R12: `fwd_valid`, `fwd_addr`, `fwd_rw` and `fwd_to_dev` are registered and appear one cycle after the address byte is valid. There is one strobe per valid byte, including back-to-back bytes, and `fwd_rw` equals bit 0 of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 deserializer, 1 physical, 2 alias) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| link_lock | input | 1 | Receive lock from the link side |
| link_dev_id | input | 7 | Deserializer ID offered by the link side |
| addr_valid | input | 1 | Address byte valid for one cycle |
| addr_byte | input | 8 | Address in bits 7:1, R/W in bit 0 |
| fwd_valid | output | 1 | Forward strobe |
| fwd_addr | output | 7 | Address to send over the link |
| fwd_rw | output | 1 | Passed-through R/W bit |
| fwd_to_dev | output | 1 | 1: deserializer target, 0: remote peripheral |

## Verification
Addresses are sent that hit the deserializer ID, hit the alias, hit neither, and equal both IDs at once. These patterns separate pass-through forwarding from remapping and check the priority order. The same addresses are repeated with each ID cleared to zero, which shows that a zero ID turns its match off rather than matching address 0. Back-to-back bytes with both R/W values check the one-cycle latency and the per-byte strobe. Lock edges are driven with lock held high, with freeze set, and together with a software write, which separates a load on the edge from a load on the level and shows the write taking precedence.

// File: rtl/alias_remap_pkg.sv
package alias_remap_pkg;
    typedef enum logic [1:0] {
        SEL_DEV   = 2'd0,
        SEL_PHYS  = 2'd1,
        SEL_ALIAS = 2'd2,
        SEL_NONE  = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/alias_cfg_regs.sv
module alias_cfg_regs
    import alias_remap_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    sel,
    input  logic [AW:0]   wdata,
    input  logic          link_lock,
    input  logic [AW-1:0] link_id,
    output logic [AW-1:0] dev_id,
    output logic          dev_frz,
    output logic [AW-1:0] phys_id,
    output logic [AW-1:0] alias_id,
    output logic          lock_q,
    output logic [AW:0]   rdata
);
    typedef struct packed {
        logic [AW-1:0] dev;
        logic          frz;
        logic [AW-1:0] phys;
        logic [AW-1:0] ali;
        logic          lock;
    } regs_t;

    regs_t    st_d, st_q;
    cfg_sel_e sel_e;
    logic     load_edge;

    assign sel_e = cfg_sel_e'(sel);

    always_comb begin
        st_d      = st_q;
        st_d.lock = link_lock;
        load_edge = link_lock && !st_q.lock && !st_q.frz;
        if (load_edge) begin
            st_d.dev = link_id;
        end
        // the software write is applied last so it overrides a same-cycle load
        if (wr_en) begin
            unique case (sel_e)
                SEL_DEV: begin
                    st_d.dev = wdata[AW:1];
                    st_d.frz = wdata[0];
                end
                SEL_PHYS:  st_d.phys = wdata[AW:1];
                SEL_ALIAS: st_d.ali  = wdata[AW:1];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel_e)
            SEL_DEV:   rdata = {st_q.dev, st_q.frz};
            SEL_PHYS:  rdata = {st_q.phys, 1'b0};
            SEL_ALIAS: rdata = {st_q.ali, 1'b0};
            default:   rdata = '0;
        endcase
    end

    assign dev_id   = st_q.dev;
    assign dev_frz  = st_q.frz;
    assign phys_id  = st_q.phys;
    assign alias_id = st_q.ali;
    assign lock_q   = st_q.lock;
endmodule

// File: rtl/alias_addr_match.sv
module alias_addr_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] dev_id,
    input  logic [AW-1:0] alias_id,
    output logic          dev_hit,
    output logic          alias_hit
);
    localparam int NT = 2;

    logic [NT-1:0][AW-1:0] ids;
    logic [NT-1:0]         raw;

    assign ids[0] = dev_id;
    assign ids[1] = alias_id;

    for (genvar g = 0; g < NT; g++) begin : g_cmp
        // a zero entry is switched off
        assign raw[g] = (ids[g] != '0) && (ids[g] == addr);
    end

    assign dev_hit   = raw[0];
    assign alias_hit = raw[1] && !raw[0];
endmodule

// File: rtl/alias_fwd_stage.sv
module alias_fwd_stage #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_valid,
    input  logic [AW:0]   addr_byte,
    input  logic          dev_hit,
    input  logic          alias_hit,
    input  logic [AW-1:0] phys_id,
    output logic          fwd_valid,
    output logic [AW-1:0] fwd_addr,
    output logic          fwd_rw,
    output logic          fwd_to_dev
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        logic          rw;
        logic          to_dev;
    } fwd_t;

    fwd_t fw_d, fw_q;

    always_comb begin
        fw_d     = fw_q;
        fw_d.vld = addr_valid && (dev_hit || alias_hit);
        if (addr_valid) begin
            fw_d.addr   = dev_hit ? addr_byte[AW:1] : phys_id;
            fw_d.rw     = addr_byte[0];
            fw_d.to_dev = dev_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fw_q <= '0;
        end else begin
            fw_q <= fw_d;
        end
    end

    assign fwd_valid  = fw_q.vld;
    assign fwd_addr   = fw_q.addr;
    assign fwd_rw     = fw_q.rw;
    assign fwd_to_dev = fw_q.to_dev;
endmodule

// File: rtl/i2c_alias_remap.sv
module i2c_alias_remap #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr_en,
    input  logic [1:0]    cfg_sel,
    input  logic [AW:0]   cfg_wdata,
    output logic [AW:0]   cfg_rdata,
    input  logic          link_lock,
    input  logic [AW-1:0] link_dev_id,
    input  logic          addr_valid,
    input  logic [AW:0]   addr_byte,
    output logic          fwd_valid,
    output logic [AW-1:0] fwd_addr,
    output logic          fwd_rw,
    output logic          fwd_to_dev
);
    logic [AW-1:0] dev_id, phys_id, alias_id;
    logic          dev_frz, lock_q;
    logic          dev_hit, alias_hit;

    alias_cfg_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .link_lock(link_lock),
        .link_id  (link_dev_id),
        .dev_id   (dev_id),
        .dev_frz  (dev_frz),
        .phys_id  (phys_id),
        .alias_id (alias_id),
        .lock_q   (lock_q),
        .rdata    (cfg_rdata)
    );

    alias_addr_match #(.AW(AW)) u_match (
        .addr     (addr_byte[AW:1]),
        .dev_id   (dev_id),
        .alias_id (alias_id),
        .dev_hit  (dev_hit),
        .alias_hit(alias_hit)
    );

    alias_fwd_stage #(.AW(AW)) u_fwd (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_valid(addr_valid),
        .addr_byte (addr_byte),
        .dev_hit   (dev_hit),
        .alias_hit (alias_hit),
        .phys_id   (phys_id),
        .fwd_valid (fwd_valid),
        .fwd_addr  (fwd_addr),
        .fwd_rw    (fwd_rw),
        .fwd_to_dev(fwd_to_dev)
    );
endmodule

// File: rtl/i2c_alias_remap_chk.sv
module i2c_alias_remap_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr_en,
    input logic [1:0]    cfg_sel,
    input logic          link_lock,
    input logic          lock_q,
    input logic          addr_valid,
    input logic [AW:0]   addr_byte,
    input logic          fwd_valid,
    input logic [AW-1:0] fwd_addr,
    input logic          fwd_rw,
    input logic          fwd_to_dev,
    input logic [AW-1:0] dev_id,
    input logic          dev_frz,
    input logic [AW-1:0] phys_id,
    input logic [AW-1:0] alias_id
);
    logic wr_dev;
    assign wr_dev = cfg_wr_en && (cfg_sel == 2'd0);

    // R12
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> $past(addr_valid));

    // R12
    rw_passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_rw == $past(addr_byte[0]));

    // R3
    dev_unchanged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_to_dev) |-> (fwd_addr == $past(addr_byte[AW:1])) && ($past(dev_id) != '0));

    // R4
    alias_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_to_dev) |-> (fwd_addr == $past(phys_id)) && ($past(addr_byte[AW:1]) == $past(alias_id)));

    // R5
    alias_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_to_dev) |-> $past(alias_id) != '0);

    // R7
    dev_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_to_dev) |-> ($past(dev_id) == '0) || ($past(dev_id) != $past(addr_byte[AW:1])));

    // R9
    load_on_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_dev && !(link_lock && !lock_q)) |=> $stable(dev_id));

    // R10
    freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_frz && !wr_dev) |=> $stable(dev_id));
endmodule

bind i2c_alias_remap i2c_alias_remap_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_sel   (cfg_sel),
    .link_lock (link_lock),
    .lock_q    (lock_q),
    .addr_valid(addr_valid),
    .addr_byte (addr_byte),
    .fwd_valid (fwd_valid),
    .fwd_addr  (fwd_addr),
    .fwd_rw    (fwd_rw),
    .fwd_to_dev(fwd_to_dev),
    .dev_id    (dev_id),
    .dev_frz   (dev_frz),
    .phys_id   (phys_id),
    .alias_id  (alias_id)
);

// File: tb/i2c_alias_remap_test.sv
`timescale 1ns/1ps
module i2c_alias_remap_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [1:0] cfg_sel = 2'd3;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       link_lock = 1'b0;
    logic [6:0] link_dev_id = '0;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       fwd_valid;
    logic [6:0] fwd_addr;
    logic       fwd_rw;
    logic       fwd_to_dev;

    always #2 clk = ~clk;

    i2c_alias_remap uut (.*);

    typedef struct {
        logic       fwd;
        logic [6:0] addr;
        logic       rw;
        logic       to_dev;
        string      tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    errs   = 0;
    bit    done   = 0;
    logic  mon_pend = 1'b0;

    logic [6:0] m_dev = '0, m_per = '0, m_ali = '0;

    always @(posedge clk) mon_pend <= addr_valid && rst_n;

    // monitor: pops one expected item per byte the design saw
    always @(negedge clk) begin
        if (mon_pend) begin
            item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                errs++;
                $display("FAIL %s: no expected item, got valid=%0b", "R12", fwd_valid);
            end else begin
                it = exp_q.pop_front();
                if (fwd_valid !== it.fwd ||
                    (it.fwd && (fwd_addr !== it.addr || fwd_rw !== it.rw || fwd_to_dev !== it.to_dev))) begin
                    errs++;
                    $display("FAIL %s: got v=%0b a=%h rw=%0b dev=%0b exp v=%0b a=%h rw=%0b dev=%0b",
                             it.tag, fwd_valid, fwd_addr, fwd_rw, fwd_to_dev,
                             it.fwd, it.addr, it.rw, it.to_dev);
                end
            end
        end else if (rst_n && fwd_valid) begin
            checks++;
            errs++;
            $display("FAIL R12: strobe without byte, got 1 exp 0");
        end
    end

    function automatic item_t predict(logic [6:0] a, logic rw, string tag);
        item_t it;
        logic dh, ah;
        dh = (m_dev != 0) && (a == m_dev);
        ah = (m_ali != 0) && (a == m_ali);
        it.fwd    = dh || ah;
        it.addr   = dh ? a : m_per;
        it.rw     = rw;
        it.to_dev = dh;
        it.tag    = tag;
        return it;
    endfunction

    task automatic drive_byte(logic [6:0] a, logic rw, string tag);
        @(negedge clk);
        addr_valid = 1'b1;
        addr_byte  = {a, rw};
        exp_q.push_back(predict(a, rw, tag));
    endtask

    task automatic send(logic [6:0] a, logic rw, string tag);
        drive_byte(a, rw, tag);
        @(negedge clk);
        addr_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] s, logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
    endtask

    task automatic rd_check(logic [1:0] s, logic [7:0] exp, string tag);
        @(negedge clk);
        cfg_sel = s;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errs++;
            $display("FAIL %s: sel %0d got %h exp %h", tag, s, cfg_rdata, exp);
        end
        cfg_sel = 2'd3;
    endtask

    task automatic lock_pulse(logic [6:0] id);
        @(negedge clk);
        link_dev_id = id;
        link_lock   = 1'b1;
        @(negedge clk);
        @(negedge clk);
        link_lock   = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: run hung, got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if (fwd_valid !== 1'b0) begin errs++; $display("FAIL R1: fwd_valid got %0b exp 0", fwd_valid); end
        rd_check(2'd0, 8'h00, "R1");
        rd_check(2'd1, 8'h00, "R1");
        rd_check(2'd2, 8'h00, "R1");
        send(7'h00, 1'b0, "R1");
        send(7'h50, 1'b1, "R1");

        // R2 layouts
        wr(2'd0, {7'h50, 1'b0}); m_dev = 7'h50;
        wr(2'd1, {7'h21, 1'b1}); m_per = 7'h21;
        wr(2'd2, {7'h61, 1'b1}); m_ali = 7'h61;
        rd_check(2'd0, 8'hA0, "R2");
        rd_check(2'd1, 8'h42, "R2");
        rd_check(2'd2, 8'hC2, "R2");
        rd_check(2'd3, 8'h00, "R2");

        // R3 / R4 / R8 forwarding
        send(7'h50, 1'b1, "R3");
        send(7'h50, 1'b0, "R3");
        send(7'h61, 1'b0, "R4");
        send(7'h61, 1'b1, "R4");
        send(7'h33, 1'b0, "R8");
        send(7'h21, 1'b1, "R8");

        // R12 back-to-back bytes
        drive_byte(7'h61, 1'b1, "R12");
        drive_byte(7'h50, 1'b0, "R12");
        drive_byte(7'h33, 1'b1, "R12");
        @(negedge clk); addr_valid = 1'b0;
        @(negedge clk);

        // R7 priority
        wr(2'd2, {7'h50, 1'b0}); m_ali = 7'h50;
        send(7'h50, 1'b1, "R7");

        // R5 alias zero
        wr(2'd2, 8'h00); m_ali = 7'h00;
        send(7'h00, 1'b0, "R5");
        send(7'h61, 1'b0, "R5");

        // R6 device zero
        wr(2'd2, {7'h61, 1'b0}); m_ali = 7'h61;
        wr(2'd0, 8'h00); m_dev = 7'h00;
        send(7'h00, 1'b1, "R6");
        send(7'h50, 1'b1, "R6");
        send(7'h61, 1'b0, "R6");

        // R9 autoload on rising edge only
        @(negedge clk);
        link_dev_id = 7'h2A; link_lock = 1'b1;
        @(negedge clk);
        m_dev = 7'h2A;
        rd_check(2'd0, {7'h2A, 1'b0}, "R9");
        link_dev_id = 7'h13;
        repeat (3) @(negedge clk);
        rd_check(2'd0, {7'h2A, 1'b0}, "R9");
        send(7'h2A, 1'b0, "R9");
        link_lock = 1'b0;
        @(negedge clk);
        lock_pulse(7'h15); m_dev = 7'h15;
        rd_check(2'd0, {7'h15, 1'b0}, "R9");

        // R10 freeze
        wr(2'd0, {7'h23, 1'b1}); m_dev = 7'h23;
        lock_pulse(7'h44);
        rd_check(2'd0, {7'h23, 1'b1}, "R10");
        send(7'h23, 1'b1, "R10");
        send(7'h44, 1'b1, "R10");

        // R11 write and autoload in the same cycle
        wr(2'd0, {7'h23, 1'b0});
        @(negedge clk);
        link_dev_id = 7'h55; link_lock = 1'b1;
        cfg_wr_en = 1'b1; cfg_sel = 2'd0; cfg_wdata = {7'h3C, 1'b0};
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_sel = 2'd3;
        m_dev = 7'h3C;
        rd_check(2'd0, {7'h3C, 1'b0}, "R11");
        send(7'h3C, 1'b0, "R11");
        link_lock = 1'b0;
        repeat (2) @(negedge clk);

        checks++;
        if (exp_q.size() != 0) begin
            errs++;
            $display("FAIL R12: %0d items left, exp 0", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule